// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a chip. It follows the standard sixteen-state test clock state machine, which advances on every rising edge of the test clock according to the mode-select input. The block holds a three-bit instruction register and decodes six instructions from it. The decoded instruction picks one of three data registers to sit between the serial input and the serial output: a one-bit bypass stage, a boundary register whose length is a parameter, or a 32-bit identification register.

The instruction decode also drives two mode outputs toward the pad ring. One tells the pad muxes to take their values from the boundary register's parallel outputs instead of from the core. The other tells them to float every output. The instruction register and the boundary register's parallel outputs change on the falling test-clock edge. The serial output also changes on that edge, so the next device on the chain sees a stable bit at its rising edge.

The reset input is active high and synchronous to the test clock. Holding the mode-select input high for five rising edges has the same effect.

Top module: `tap_ctrl`

## Requirements
- R1: A rising `tck` edge with `tap_rst` high enters Test-Logic-Reset. While in that state, the active instruction is set to IDCODE (001), or to BYPASS (111) when `HAS_ID` is 0. Both mode outputs are then low.
- R2: Five consecutive rising `tck` edges with `tms` high reach Test-Logic-Reset from any state, and the active instruction returns to the reset instruction of R1.
- R3: The state machine follows the standard transitions. From Exit2-IR, `tms` low returns to Shift-IR and `tms` high goes to Update-IR. From Update-IR, `tms` low goes to Run-Test/Idle. A scan that pauses in Pause-IR still assembles the complete instruction.
- R4: Capture-IR loads 001 into the instruction shift stage, so the first bits shifted out read 1 then 0 then 0. The shifted instruction becomes active on the falling `tck` edge after Update-IR is entered.
- R5: The opcodes are EXTEST 000, IDCODE 001, SAMPLE/PRELOAD 010, CLAMP 011, HIGHZ 100 and BYPASS 111. Any other code (101, 110) behaves as BYPASS, with both mode outputs low.
- R6: With the bypass stage selected, Capture-DR loads 0 into it. Shift-DR then delays `tdi` by one bit, so shifting n bits returns {din[n-2:0], 0}.
- R7: Under IDCODE, Capture-DR loads `ID_VALUE` with bit 0 forced to 1. Its 32 bits shift out least significant bit first.
- R8: Under SAMPLE/PRELOAD, Capture-DR loads `pin_in` into the boundary register, and Shift-DR shifts from `tdi` toward `tdo`, LSB first. Update-DR copies the shifted value to `bsr_out` on the falling edge. `pin_sel_bsr` stays low.
- R9: Under EXTEST, `pin_sel_bsr` is high, Capture-DR samples `pin_in`, and Update-DR loads `bsr_out`.
- R10: Under CLAMP, `pin_sel_bsr` is high and `pin_hiz` is low. The bypass stage is selected, and `bsr_out` keeps its value through any DR scan.
- R11: Under HIGHZ, `pin_hiz` is high and `pin_sel_bsr` is low, and the bypass stage is selected.
- R12: `tdo` and `tdo_en` change on the falling `tck` edge. `tdo_en` is high only in the half-cycle windows that follow Shift-IR or Shift-DR. Outside those windows `tdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tap_rst | input | 1 | Synchronous active-high reset of the port |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data into the selected register |
| pin_in | input | BSR_W | Pin values captured into the boundary register |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_en | output | 1 | High while shifted data is valid on `tdo` |
| bsr_out | output | BSR_W | Boundary register parallel outputs toward the pads |
| pin_sel_bsr | output | 1 | Pads take values from `bsr_out` instead of the core |
| pin_hiz | output | 1 | Pads float all outputs |

## Verification
The bench builds the block with `BSR_W` = 8, `HAS_ID` = 1 and a 32-bit identification value whose nibbles all differ. With these values, every boundary bit can be toggled by an eight-bit pattern, and a misplaced or swapped identification bit shows up at the serial output. With the identification register fitted, the reset instruction is IDCODE. A scan straight after reset, after a mid-run reset pulse or after five mode-select highs therefore tells the three reset paths apart from a leftover instruction. The variant with `HAS_ID` = 0 is not built by the bench, so its BYPASS reset default is covered only by the RTL.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLE = 3'b010;
    localparam logic [IR_W-1:0] OP_CLAMP  = 3'b011;
    localparam logic [IR_W-1:0] OP_HIGHZ  = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;

    // Pattern placed in the instruction shift stage by Capture-IR
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    typedef enum logic [1:0] { DR_BYPASS, DR_BSR, DR_ID } dr_sel_e;

    typedef struct packed {
        dr_sel_e sel;
        logic    drive_bsr;
        logic    hiz;
    } ir_decode_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
        tap_state_e n;
        case (s)
            ST_TLR:    n = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    n = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: n = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = tms ? ST_SEL_DR : ST_RTI;
            default:   n = ST_TLR;
        endcase
        return n;
    endfunction

    function automatic ir_decode_t ir_decode(input logic [IR_W-1:0] op);
        ir_decode_t d;
        d = '{sel: DR_BYPASS, drive_bsr: 1'b0, hiz: 1'b0};
        case (op)
            OP_EXTEST: d = '{sel: DR_BSR,    drive_bsr: 1'b1, hiz: 1'b0};
            OP_IDCODE: d = '{sel: DR_ID,     drive_bsr: 1'b0, hiz: 1'b0};
            OP_SAMPLE: d = '{sel: DR_BSR,    drive_bsr: 1'b0, hiz: 1'b0};
            OP_CLAMP:  d = '{sel: DR_BYPASS, drive_bsr: 1'b1, hiz: 1'b0};
            OP_HIGHZ:  d = '{sel: DR_BYPASS, drive_bsr: 1'b0, hiz: 1'b1};
            default:   d = '{sel: DR_BYPASS, drive_bsr: 1'b0, hiz: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       tap_rst,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge tck) begin
        if (tap_rst) state <= ST_TLR;
        else         state <= tap_next(state, tms);
    end

    // Run length of consecutive tms-high edges, used only by the check below
    logic [2:0] hi_run;
    always_ff @(posedge tck) begin
        if (tap_rst || !tms)     hi_run <= '0;
        else if (hi_run != 3'd7) hi_run <= hi_run + 3'd1;
    end

    assert_reset_entry_R1: assert property (@(posedge tck)
        tap_rst |=> (state == ST_TLR));

    assert_five_high_R2: assert property (@(posedge tck) disable iff (tap_rst)
        (tms && hi_run >= 3'd4) |=> (state == ST_TLR));

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
    import tap_pkg::*;
#(
    parameter logic [IR_W-1:0] RESET_OP = OP_IDCODE
) (
    input  logic            tck,
    input  logic            tap_rst,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic            ir_tdo,
    output logic [IR_W-1:0] ir_cur
);

    logic [IR_W-1:0] ir_sh;

    always_ff @(posedge tck) begin
        if (tap_rst) begin
            ir_sh <= IR_CAPTURE;
        end else begin
            case (state)
                ST_CAP_IR: ir_sh <= IR_CAPTURE;
                ST_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
                default:   ir_sh <= ir_sh;
            endcase
        end
    end

    // Active instruction changes on the falling edge
    always_ff @(negedge tck) begin
        if (tap_rst || state == ST_TLR) ir_cur <= RESET_OP;
        else if (state == ST_UPD_IR)    ir_cur <= ir_sh;
    end

    assign ir_tdo = ir_sh[0];

    assert_ir_update_R4: assert property (@(posedge tck) disable iff (tap_rst)
        (state == ST_UPD_IR) |=> (ir_cur == $past(ir_sh)));

    assert_tlr_instr_R1: assert property (@(posedge tck) disable iff (tap_rst)
        (state == ST_TLR) |=> (ir_cur == RESET_OP));

endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr
    import tap_pkg::*;
#(
    parameter int              BSR_W    = 8,
    parameter bit              HAS_ID   = 1'b1,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h0A5C_3E17
) (
    input  logic             tck,
    input  logic             tap_rst,
    input  tap_state_e       state,
    input  dr_sel_e          sel,
    input  logic             tdi,
    input  logic [BSR_W-1:0] pin_in,
    output logic             dr_tdo,
    output logic [BSR_W-1:0] bsr_out
);

    logic             byp;
    logic [BSR_W-1:0] bsr_sh;
    logic             id_tdo;

    wire cap = (state == ST_CAP_DR);
    wire sh  = (state == ST_SH_DR);

    // One-bit bypass stage
    always_ff @(posedge tck) begin
        if (tap_rst)                       byp <= 1'b0;
        else if (sel == DR_BYPASS && cap)  byp <= 1'b0;
        else if (sel == DR_BYPASS && sh)   byp <= tdi;
    end

    // Boundary shift stage
    always_ff @(posedge tck) begin
        if (tap_rst)                   bsr_sh <= '0;
        else if (sel == DR_BSR && cap) bsr_sh <= pin_in;
        else if (sel == DR_BSR && sh)  bsr_sh <= {tdi, bsr_sh[BSR_W-1:1]};
    end

    // Boundary parallel outputs, loaded on the falling edge in Update-DR
    always_ff @(negedge tck) begin
        if (tap_rst)                                  bsr_out <= '0;
        else if (state == ST_UPD_DR && sel == DR_BSR) bsr_out <= bsr_sh;
    end

    generate
        if (HAS_ID) begin : g_id
            logic [ID_W-1:0] id_sh;
            always_ff @(posedge tck) begin
                if (tap_rst)                  id_sh <= '0;
                else if (sel == DR_ID && cap) id_sh <= {ID_VALUE[ID_W-1:1], 1'b1};
                else if (sel == DR_ID && sh)  id_sh <= {tdi, id_sh[ID_W-1:1]};
            end
            assign id_tdo = id_sh[0];

            assert_id_lsb_R7: assert property (@(posedge tck) disable iff (tap_rst)
                (cap && sel == DR_ID) |=> dr_tdo);
        end else begin : g_no_id
            assign id_tdo = 1'b0;
        end
    endgenerate

    always_comb begin
        case (sel)
            DR_BSR:  dr_tdo = bsr_sh[0];
            DR_ID:   dr_tdo = id_tdo;
            default: dr_tdo = byp;
        endcase
    end

    assert_bypass_delay_R6: assert property (@(posedge tck) disable iff (tap_rst)
        (sh && sel == DR_BYPASS && $past(state) == ST_SH_DR && $past(sel) == DR_BYPASS)
        |-> (dr_tdo == $past(tdi)));

endmodule

// File: rtl/tap_ctrl.sv
`timescale 1ns/1ps
module tap_ctrl
    import tap_pkg::*;
#(
    parameter int              BSR_W    = 8,
    parameter bit              HAS_ID   = 1'b1,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h0A5C_3E17
) (
    input  logic             tck,
    input  logic             tap_rst,
    input  logic             tms,
    input  logic             tdi,
    input  logic [BSR_W-1:0] pin_in,
    output logic             tdo,
    output logic             tdo_en,
    output logic [BSR_W-1:0] bsr_out,
    output logic             pin_sel_bsr,
    output logic             pin_hiz
);

    localparam logic [IR_W-1:0] RESET_OP = HAS_ID ? OP_IDCODE : OP_BYPASS;

    tap_state_e      state;
    logic [IR_W-1:0] ir_cur;
    logic            ir_tdo;
    logic            dr_tdo;
    ir_decode_t      dec;
    dr_sel_e         sel;
    logic            tdo_q;

    tap_fsm u_fsm (
        .tck     (tck),
        .tap_rst (tap_rst),
        .tms     (tms),
        .state   (state)
    );

    tap_ir #(.RESET_OP(RESET_OP)) u_ir (
        .tck     (tck),
        .tap_rst (tap_rst),
        .state   (state),
        .tdi     (tdi),
        .ir_tdo  (ir_tdo),
        .ir_cur  (ir_cur)
    );

    always_comb begin
        dec = ir_decode(ir_cur);
        sel = (dec.sel == DR_ID && !HAS_ID) ? DR_BYPASS : dec.sel;
    end

    tap_dr #(.BSR_W(BSR_W), .HAS_ID(HAS_ID), .ID_VALUE(ID_VALUE)) u_dr (
        .tck     (tck),
        .tap_rst (tap_rst),
        .state   (state),
        .sel     (sel),
        .tdi     (tdi),
        .pin_in  (pin_in),
        .dr_tdo  (dr_tdo),
        .bsr_out (bsr_out)
    );

    // Serial output retimed to the falling edge
    always_ff @(negedge tck) begin
        if (tap_rst) begin
            tdo_q  <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= (state == ST_SH_IR) || (state == ST_SH_DR);
            tdo_q  <= (state == ST_SH_IR) ? ir_tdo :
                      (state == ST_SH_DR) ? dr_tdo : 1'b0;
        end
    end

    assign tdo         = tdo_en & tdo_q;
    assign pin_sel_bsr = dec.drive_bsr;
    assign pin_hiz     = dec.hiz;

    assert_clamp_hold_R10: assert property (@(posedge tck) disable iff (tap_rst)
        (ir_cur == OP_CLAMP) |=> (ir_cur != OP_CLAMP || $stable(bsr_out)));

    assert_hiz_excl_R11: assert property (@(posedge tck) disable iff (tap_rst)
        pin_hiz |-> !pin_sel_bsr);

    assert_tdo_quiet_R12: assert property (@(posedge tck) disable iff (tap_rst)
        (state != ST_SH_IR && state != ST_SH_DR &&
         $past(state) != ST_SH_IR && $past(state) != ST_SH_DR)
        |-> (!tdo_en && !tdo));

endmodule

// File: tb/tap_ctrl_test.sv
`timescale 1ns/1ps
module tap_ctrl_test;

    localparam int          BSR_W = 8;
    localparam logic [31:0] ID    = 32'h0A5C_3E17;

    logic tck = 1'b0;
    logic tap_rst, tms, tdi;
    logic [BSR_W-1:0] pin_in;
    logic tdo, tdo_en, pin_sel_bsr, pin_hiz;
    logic [BSR_W-1:0] bsr_out;

    always #2 tck = ~tck;

    tap_ctrl #(.BSR_W(BSR_W), .HAS_ID(1'b1), .ID_VALUE(ID)) uut (
        .tck(tck), .tap_rst(tap_rst), .tms(tms), .tdi(tdi), .pin_in(pin_in),
        .tdo(tdo), .tdo_en(tdo_en), .bsr_out(bsr_out),
        .pin_sel_bsr(pin_sel_bsr), .pin_hiz(pin_hiz)
    );

    typedef struct { string tag; logic [63:0] v; } item_t;
    item_t exp_q[$];
    item_t act_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Driver side: expected and observed items go into separate queues
    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        item_t e, a;
        e.tag = tag; e.v = exp;
        a.tag = tag; a.v = act;
        exp_q.push_back(e);
        act_q.push_back(a);
    endtask

    // Monitor: pops and compares as results arrive
    initial begin
        forever begin
            @(posedge tck);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                item_t e, a;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                checks++;
                if (a.v !== e.v) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", e.tag, a.v, e.v);
                end
            end
        end
    end

    bit en_ok;

    task automatic step(input logic m, input logic d, output logic q);
        @(negedge tck);
        #1;
        tms = m;
        tdi = d;
        q = tdo;
        @(posedge tck);
    endtask

    // Full scan from Run-Test/Idle back to Run-Test/Idle
    task automatic scan(input bit is_ir, input int n, input logic [63:0] din,
                        output logic [63:0] dout);
        logic q;
        dout = '0;
        step(1'b1, 1'b0, q);
        if (is_ir) step(1'b1, 1'b0, q);
        step(1'b0, 1'b0, q);
        step(1'b0, 1'b0, q);
        for (int i = 0; i < n; i++) begin
            @(negedge tck);
            #1;
            if (!tdo_en) en_ok = 0;
            tms = (i == n - 1);
            tdi = din[i];
            dout[i] = tdo;
            @(posedge tck);
        end
        step(1'b1, 1'b0, q);
        step(1'b0, 1'b0, q);
    endtask

    task automatic idle_probe(input string tag);
        @(negedge tck);
        #1;
        check({tag, " tdo_en idle"}, tdo_en, 0);
        check({tag, " tdo idle"}, tdo, 0);
    endtask

    initial begin
        logic [63:0] r;
        logic q;
        tap_rst = 1'b1; tms = 1'b1; tdi = 1'b0; pin_in = '0; en_ok = 1;
        repeat (3) @(posedge tck);
        @(negedge tck); #1; tap_rst = 1'b0;
        step(1'b0, 1'b0, q);

        // R1 reset state
        @(negedge tck); #1;
        check("R1 pin_sel_bsr after reset", pin_sel_bsr, 0);
        check("R1 pin_hiz after reset", pin_hiz, 0);
        check("R1 bsr_out after reset", bsr_out, 0);
        idle_probe("R12");
        scan(0, 32, 64'h0, r);
        check("R1 R7 identification after reset", r, {32'h0, ID});

        // R4 capture pattern, load BYPASS
        scan(1, 3, 64'h7, r);
        check("R4 captured instruction pattern", r, 64'h1);
        scan(0, 8, 64'hB4, r);
        check("R6 bypass delay", r, 64'h68);

        // R8 SAMPLE/PRELOAD
        scan(1, 3, 64'h2, r);
        pin_in = 8'hA5;
        scan(0, 8, 64'h3C, r);
        check("R8 sampled pins", r, 64'hA5);
        check("R8 preload to bsr_out", bsr_out, 8'h3C);
        check("R8 pin_sel_bsr low", pin_sel_bsr, 0);

        // R9 EXTEST
        scan(1, 3, 64'h0, r);
        check("R9 pin_sel_bsr high", pin_sel_bsr, 1);
        pin_in = 8'h5A;
        scan(0, 8, 64'h0F, r);
        check("R9 captured pins", r, 64'h5A);
        check("R9 bsr_out updated", bsr_out, 8'h0F);

        // R3 CLAMP loaded through Pause-IR and Exit2-IR
        step(1'b1, 1'b0, q);
        step(1'b1, 1'b0, q);
        step(1'b0, 1'b0, q);
        step(1'b0, 1'b0, q);
        r = '0;
        step(1'b0, 1'b1, q); r[0] = q;
        step(1'b1, 1'b1, q); r[1] = q;
        step(1'b0, 1'b0, q);
        step(1'b1, 1'b0, q);
        step(1'b0, 1'b0, q);
        step(1'b1, 1'b0, q); r[2] = q;
        step(1'b1, 1'b0, q);
        step(1'b0, 1'b0, q);
        check("R3 paused IR scan output", r, 64'h1);
        @(negedge tck); #1;
        check("R10 R3 clamp pin_sel_bsr", pin_sel_bsr, 1);
        check("R10 clamp pin_hiz", pin_hiz, 0);
        scan(0, 8, 64'hFF, r);
        check("R10 clamp uses bypass", r, 64'hFE);
        check("R10 bsr_out held", bsr_out, 8'h0F);

        // R11 HIGHZ
        scan(1, 3, 64'h4, r);
        @(negedge tck); #1;
        check("R11 pin_hiz high", pin_hiz, 1);
        check("R11 pin_sel_bsr low", pin_sel_bsr, 0);
        scan(0, 8, 64'h81, r);
        check("R11 highz uses bypass", r, 64'h02);

        // R5 undefined code
        scan(1, 3, 64'h5, r);
        @(negedge tck); #1;
        check("R5 code 101 mode outputs", {pin_sel_bsr, pin_hiz}, 0);
        scan(0, 8, 64'h55, r);
        check("R5 code 101 as bypass", r, 64'hAA);
        check("R5 bsr_out unchanged", bsr_out, 8'h0F);

        // R2 five tms highs from Shift-DR
        step(1'b1, 1'b0, q);
        step(1'b0, 1'b0, q);
        step(1'b0, 1'b0, q);
        repeat (5) step(1'b1, 1'b0, q);
        step(1'b0, 1'b0, q);
        scan(0, 32, 64'h0, r);
        check("R2 identification after tms reset", r, {32'h0, ID});

        // R1 reset pulse mid-run
        scan(1, 3, 64'h3, r);
        @(negedge tck); #1; tap_rst = 1'b1;
        @(posedge tck);
        @(negedge tck); #1; tap_rst = 1'b0; tms = 1'b0;
        @(posedge tck);
        @(negedge tck); #1;
        check("R1 pin_sel_bsr cleared by reset", pin_sel_bsr, 0);
        scan(0, 32, 64'h0, r);
        check("R1 identification after reset pulse", r, {32'h0, ID});

        check("R12 tdo_en high through every shift", en_ok, 1);
        idle_probe("R12 end");

        repeat (3) @(posedge tck);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 50000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule